// File: doc/BRIEF.md
# Capability Fault Cause and Exception Redirect Unit

This unit sits beside the capability-check logic of a processor with 32 capability registers. When a check fails, the checker presents a fault request. The request carries a fault kind and, if the fault concerns a particular capability register, that register's 5-bit index. The unit turns the kind into an 8-bit cause code and packs it with the register field into a 16-bit cause register. It then pulses an exception strobe and selects one of two exceptions: the dedicated trap exception or the general capability exception.

In the same cycle, the unit produces the write of the exception capability register (register 31). The value written is the current program-counter capability with its offset field replaced by the current PC. The next and delayed program-counter capabilities are both redirected to the kernel code capability (register 29). On an exception-return request, both are instead reloaded from register 31.

A combinational port reports whether a queried register index is a protected system register that the current PC capability may not access.

The fault request is a valid/ready input. Back-pressure rules:
- `flt_ready` is low during reset and in any cycle where `eret_req` is high. Exception return takes priority.
- A stalled request must be held stable until it is accepted.
- A request is accepted on a rising edge where both `flt_valid` and `flt_ready` are high.

Top module: `cap_exc_cause_unit`

## Requirements
- R1: While reset is active, `cause` is 0x0000, `exc_strobe` and `epcc_wr_valid` are 0, and `next_pcc` and `delayed_pcc` are all zeros.
- R2: An accepted fault sets `cause[15:8]` one cycle later to the code for its kind. Kinds 0..10 map to codes 0x00..0x0A: none, length, tag, seal, type, call trap, return trap, trusted-stack underflow, user-defined, TLB no-store-capability, inexact bounds. Kinds 11..19 map to codes 0x10..0x18: global, execute permission, load, store, load-capability, store-capability, store-local-capability, seal permission, system-register access.
- R3: For an accepted fault with `flt_has_reg`=1, `cause[7:0]` is the 5-bit `flt_reg` zero-extended. With `flt_has_reg`=0 it is 0xFF.
- R4: `exc_strobe` is high for exactly one cycle per accepted fault, in the same cycle the new cause appears. `exc_trap` is 1 for codes 0x05 and 0x06 and 0 for every other code.
- R5: With the strobe, `epcc_wr_valid` is 1. `epcc_wr_data` equals `pcc_in`, with bits [ADDR_W-1:0] (the offset) replaced by `pc` as sampled at acceptance.
- R6: With the strobe, `next_pcc` and `delayed_pcc` both equal `kcc_in` as sampled at acceptance.
- R7: One cycle after `eret_req`, `next_pcc` and `delayed_pcc` both equal `epcc_in`. No strobe is raised and `cause` is unchanged.
- R8: `sys_query_denied` is 1 only when `sys_query_idx` is 27..31 and `pcc_in` bit CAP_W-2 (system-register permission) is 0. All other indices are never denied.
- R9: `flt_ready` is 0 during reset or while `eret_req` is 1. A fault held through such a cycle is accepted on the first edge where `flt_ready` is 1.
- R10: Reserved kinds 20..31 record code 0x00 and select the general exception (`exc_trap`=0).
- R11: `cause` holds its value in every cycle without an accepted fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault request valid |
| flt_ready | output | 1 | Fault request can be accepted |
| flt_kind | input | 5 | Fault kind (0..19, others reserved) |
| flt_has_reg | input | 1 | Fault names a register |
| flt_reg | input | 5 | Register index of the fault |
| pc | input | ADDR_W | Current PC |
| pcc_in | input | CAP_W | Current PC capability |
| kcc_in | input | CAP_W | Register 29 (kernel code capability) |
| epcc_in | input | CAP_W | Register 31 (exception capability) read value |
| eret_req | input | 1 | Exception return request |
| cause | output | 16 | Cause register {code, register field} |
| exc_strobe | output | 1 | Exception raised this cycle |
| exc_trap | output | 1 | 1: trap exception, 0: general capability exception |
| epcc_wr_valid | output | 1 | Write register 31 |
| epcc_wr_data | output | CAP_W | Value for register 31 |
| next_pcc | output | CAP_W | Next PC capability |
| delayed_pcc | output | CAP_W | Delayed PC capability |
| sys_query_idx | input | 5 | Register index to test |
| sys_query_denied | output | 1 | Queried register is not accessible |

## Verification
Every registered result of an accepted fault is due exactly one rising edge after acceptance. This covers the cause, the strobe, the exception select, the register-31 write and both redirected capabilities. The driver issues a fault half a cycle before an edge and records its expectation in a queue. The monitor samples one time unit after each edge and takes the oldest expectation whenever the strobe is high.

Exception-return results are also due one edge later and are checked at the same point. The ready flag and the system-register query are combinational, so they are checked one time unit after the inputs change, before the next edge.

// File: rtl/cexc_pkg.sv
package cexc_pkg;
  localparam int KIND_W  = 5;
  localparam int CODE_W  = 8;
  localparam int RIDX_W  = 5;
  localparam int CAUSE_W = 2 * CODE_W;
  localparam logic [CODE_W-1:0] NO_REG_FIELD = '1;
  localparam logic [CODE_W-1:0] HIGH_GROUP_BASE = 8'h10;

  typedef enum logic [KIND_W-1:0] {
    FK_NONE       = 5'd0,
    FK_LENGTH     = 5'd1,
    FK_TAG        = 5'd2,
    FK_SEAL       = 5'd3,
    FK_TYPE       = 5'd4,
    FK_CALL_TRAP  = 5'd5,
    FK_RET_TRAP   = 5'd6,
    FK_STK_UNDER  = 5'd7,
    FK_USER       = 5'd8,
    FK_TLB_NOSTC  = 5'd9,
    FK_INEXACT    = 5'd10,
    FK_GLOBAL     = 5'd11,
    FK_P_EXEC     = 5'd12,
    FK_P_LOAD     = 5'd13,
    FK_P_STORE    = 5'd14,
    FK_P_LDCAP    = 5'd15,
    FK_P_STCAP    = 5'd16,
    FK_P_STLOCAL  = 5'd17,
    FK_P_SEAL     = 5'd18,
    FK_P_SYSREG   = 5'd19
  } flt_kind_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] regf;
  } cause_t;
endpackage

// File: rtl/cexc_code_map.sv
module cexc_code_map
  import cexc_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  output logic [CODE_W-1:0] code,
  output logic              is_trap
);
  localparam logic [CODE_W-1:0] HIGH_SHIFT =
    HIGH_GROUP_BASE - CODE_W'(FK_GLOBAL);

  always_comb begin
    if (kind <= FK_INEXACT)
      code = CODE_W'(kind);
    else if (kind <= FK_P_SYSREG)
      code = CODE_W'(kind) + HIGH_SHIFT;
    else
      code = '0;
    is_trap = (kind == FK_CALL_TRAP) || (kind == FK_RET_TRAP);
  end
endmodule

// File: rtl/cexc_cause_reg.sv
module cexc_cause_reg
  import cexc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] code,
  input  logic              trap_in,
  input  logic              has_reg,
  input  logic [RIDX_W-1:0] reg_idx,
  output cause_t            cause_q,
  output logic              strobe_q,
  output logic              trap_q
);
  cause_t next_cause;

  always_comb begin
    next_cause.code = code;
    next_cause.regf = has_reg ? CODE_W'(reg_idx) : NO_REG_FIELD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q  <= '0;
      strobe_q <= 1'b0;
      trap_q   <= 1'b0;
    end else begin
      strobe_q <= take;
      if (take) begin
        cause_q <= next_cause;
        trap_q  <= trap_in;
      end
    end
  end
endmodule

// File: rtl/cexc_pcc_redirect.sv
module cexc_pcc_redirect #(
  parameter int CAP_W  = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              eret,
  input  logic [ADDR_W-1:0] pc,
  input  logic [CAP_W-1:0]  pcc_in,
  input  logic [CAP_W-1:0]  kcc_in,
  input  logic [CAP_W-1:0]  epcc_in,
  output logic              epcc_wr_valid,
  output logic [CAP_W-1:0]  epcc_wr_data,
  output logic [CAP_W-1:0]  next_pcc,
  output logic [CAP_W-1:0]  delayed_pcc
);
  localparam int NUM_PCC = 2;
  localparam int HI_W    = CAP_W - ADDR_W;

  logic [CAP_W-1:0] pcc_q [NUM_PCC];
  logic [CAP_W-1:0] saved_pcc;

  assign saved_pcc = {pcc_in[CAP_W-1 -: HI_W], pc};

  for (genvar g = 0; g < NUM_PCC; g++) begin : g_pcc
    always_ff @(posedge clk) begin
      if (!rst_n)    pcc_q[g] <= '0;
      else if (eret) pcc_q[g] <= epcc_in;
      else if (take) pcc_q[g] <= kcc_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epcc_wr_valid <= 1'b0;
      epcc_wr_data  <= '0;
    end else begin
      epcc_wr_valid <= take;
      if (take) epcc_wr_data <= saved_pcc;
    end
  end

  assign next_pcc    = pcc_q[0];
  assign delayed_pcc = pcc_q[1];
endmodule

// File: rtl/cexc_sysreg_gate.sv
module cexc_sysreg_gate
  import cexc_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int SYS_FIRST = 27
) (
  input  logic [RIDX_W-1:0] idx,
  input  logic              sys_perm,
  output logic              denied
);
  logic [NUM_REGS-1:0] protected_mask;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_mask
    assign protected_mask[r] = (r >= SYS_FIRST);
  end

  assign denied = protected_mask[idx] && !sys_perm;
endmodule

// File: rtl/cap_exc_cause_unit.sv
module cap_exc_cause_unit
  import cexc_pkg::*;
#(
  parameter int CAP_W     = 64,
  parameter int ADDR_W    = 32,
  parameter int NUM_REGS  = 32,
  parameter int SYS_FIRST = 27
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flt_valid,
  output logic                flt_ready,
  input  logic [4:0]          flt_kind,
  input  logic                flt_has_reg,
  input  logic [4:0]          flt_reg,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [CAP_W-1:0]    pcc_in,
  input  logic [CAP_W-1:0]    kcc_in,
  input  logic [CAP_W-1:0]    epcc_in,
  input  logic                eret_req,
  output logic [15:0]         cause,
  output logic                exc_strobe,
  output logic                exc_trap,
  output logic                epcc_wr_valid,
  output logic [CAP_W-1:0]    epcc_wr_data,
  output logic [CAP_W-1:0]    next_pcc,
  output logic [CAP_W-1:0]    delayed_pcc,
  input  logic [4:0]          sys_query_idx,
  output logic                sys_query_denied
);
  localparam int SYS_PERM_BIT = CAP_W - 2;

  logic              take;
  logic [CODE_W-1:0] code;
  logic              is_trap;
  cause_t            cause_q;

  assign flt_ready = rst_n && !eret_req;
  assign take      = flt_valid && flt_ready;

  cexc_code_map u_map (
    .kind    (flt_kind),
    .code    (code),
    .is_trap (is_trap)
  );

  cexc_cause_reg u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .code     (code),
    .trap_in  (is_trap),
    .has_reg  (flt_has_reg),
    .reg_idx  (flt_reg),
    .cause_q  (cause_q),
    .strobe_q (exc_strobe),
    .trap_q   (exc_trap)
  );

  assign cause = cause_q;

  cexc_pcc_redirect #(.CAP_W(CAP_W), .ADDR_W(ADDR_W)) u_redir (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (take),
    .eret          (eret_req),
    .pc            (pc),
    .pcc_in        (pcc_in),
    .kcc_in        (kcc_in),
    .epcc_in       (epcc_in),
    .epcc_wr_valid (epcc_wr_valid),
    .epcc_wr_data  (epcc_wr_data),
    .next_pcc      (next_pcc),
    .delayed_pcc   (delayed_pcc)
  );

  cexc_sysreg_gate #(.NUM_REGS(NUM_REGS), .SYS_FIRST(SYS_FIRST)) u_gate (
    .idx      (sys_query_idx),
    .sys_perm (pcc_in[SYS_PERM_BIT]),
    .denied   (sys_query_denied)
  );
endmodule

// File: rtl/cap_exc_cause_chk.sv
module cap_exc_cause_chk #(
  parameter int CAP_W     = 64,
  parameter int ADDR_W    = 32,
  parameter int SYS_FIRST = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flt_valid,
  input logic              flt_ready,
  input logic              flt_has_reg,
  input logic [ADDR_W-1:0] pc,
  input logic [CAP_W-1:0]  pcc_in,
  input logic [CAP_W-1:0]  kcc_in,
  input logic [CAP_W-1:0]  epcc_in,
  input logic              eret_req,
  input logic [15:0]       cause,
  input logic              exc_strobe,
  input logic              exc_trap,
  input logic              epcc_wr_valid,
  input logic [CAP_W-1:0]  epcc_wr_data,
  input logic [CAP_W-1:0]  next_pcc,
  input logic [CAP_W-1:0]  delayed_pcc,
  input logic [4:0]        sys_query_idx,
  input logic              sys_query_denied
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R4
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && exc_strobe) |-> $past(flt_valid && flt_ready));

  // R3
  noreg_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(flt_valid && flt_ready && !flt_has_reg)) |-> (cause[7:0] == 8'hFF));

  // R4
  trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_strobe && exc_trap) |-> (cause[15:8] == 8'h05 || cause[15:8] == 8'h06));

  // R5
  epcc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && exc_strobe) |-> (epcc_wr_valid && epcc_wr_data[ADDR_W-1:0] == $past(pc)));

  // R6
  kcc_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && exc_strobe) |-> (next_pcc == $past(kcc_in) && delayed_pcc == $past(kcc_in)));

  // R7
  eret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(eret_req)) |->
      (next_pcc == $past(epcc_in) && delayed_pcc == $past(epcc_in) && !exc_strobe));

  // R8
  sys_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(sys_query_idx) < SYS_FIRST) || pcc_in[CAP_W-2]) |-> !sys_query_denied);

  // R9
  eret_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eret_req |-> !flt_ready);

  // R11
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(flt_valid && flt_ready)) |-> $stable(cause));
endmodule

bind cap_exc_cause_unit cap_exc_cause_chk #(
  .CAP_W(CAP_W), .ADDR_W(ADDR_W), .SYS_FIRST(SYS_FIRST)
) u_chk (.*);

// File: tb/tb_cap_exc_cause_unit.sv
module tb_cap_exc_cause_unit;
  localparam int CAP_W  = 64;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic flt_valid, flt_ready, flt_has_reg, eret_req;
  logic [4:0] flt_kind, flt_reg, sys_query_idx;
  logic [ADDR_W-1:0] pc;
  logic [CAP_W-1:0] pcc_in, kcc_in, epcc_in;
  logic [15:0] cause;
  logic exc_strobe, exc_trap, epcc_wr_valid, sys_query_denied;
  logic [CAP_W-1:0] epcc_wr_data, next_pcc, delayed_pcc;

  always #2.5 clk = ~clk;

  cap_exc_cause_unit #(.CAP_W(CAP_W), .ADDR_W(ADDR_W)) dut (.*);

  typedef struct {
    logic [15:0]      cause;
    logic             trap;
    logic [CAP_W-1:0] epcc;
    logic [CAP_W-1:0] npcc;
  } exp_t;

  exp_t exp_q[$];
  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] last_cause = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] code_of(input int k);
    case (k)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h03;
      4: return 8'h04;  5: return 8'h05;  6: return 8'h06;  7: return 8'h07;
      8: return 8'h08;  9: return 8'h09;  10: return 8'h0A; 11: return 8'h10;
      12: return 8'h11; 13: return 8'h12; 14: return 8'h13; 15: return 8'h14;
      16: return 8'h15; 17: return 8'h16; 18: return 8'h17; 19: return 8'h18;
      default: return 8'h00;   // R10 reserved kinds
    endcase
  endfunction

  // driver: presents one fault at a falling edge and records what is due next edge
  task automatic send_fault(input int k, input bit hr, input logic [4:0] ri);
    exp_t e;
    @(negedge clk);
    flt_valid   = 1'b1;
    flt_kind    = 5'(k);
    flt_has_reg = hr;
    flt_reg     = ri;
    pc          = $urandom;
    pcc_in      = {$urandom, $urandom};
    kcc_in      = {$urandom, $urandom};
    e.cause = {code_of(k), hr ? {3'b000, ri} : 8'hFF};
    e.trap  = (k == 5 || k == 6);
    e.epcc  = {pcc_in[CAP_W-1:ADDR_W], pc};
    e.npcc  = kcc_in;
    exp_q.push_back(e);
    last_cause = e.cause;
  endtask

  task automatic go_idle();
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  // monitor: one time unit after each edge, consume an expectation per strobe
  always begin
    @(posedge clk);
    #1;
    if (rst_n && exc_strobe) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected strobe", 64'(exc_strobe), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cause == e.cause, "R2/R3 cause", 64'(cause), 64'(e.cause));
        check(exc_trap == e.trap, "R4 exception select", 64'(exc_trap), 64'(e.trap));
        check(epcc_wr_valid && epcc_wr_data == e.epcc, "R5 saved pcc", epcc_wr_data, e.epcc);
        check(next_pcc == e.npcc && delayed_pcc == e.npcc, "R6 redirect", next_pcc, e.npcc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flt_valid = 1'b0; flt_kind = '0; flt_has_reg = 1'b0; flt_reg = '0;
    pc = '0; pcc_in = '0; kcc_in = '0; epcc_in = '0; eret_req = 1'b0; sys_query_idx = '0;
    repeat (3) @(posedge clk);
    #1;
    check(cause == 16'h0 && !exc_strobe && !epcc_wr_valid, "R1 reset cause", 64'(cause), 64'd0);
    check(next_pcc == '0 && delayed_pcc == '0, "R1 reset pcc", next_pcc, 64'd0);
    check(!flt_ready, "R9 ready in reset", 64'(flt_ready), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6: every kind, with and without a register, back to back
    for (int k = 0; k < 20; k++) begin
      send_fault(k, 1'b1, 5'((k * 7 + 3) % 32));
      send_fault(k, 1'b0, 5'(k));
    end
    send_fault(5, 1'b1, 5'd31);
    send_fault(6, 1'b1, 5'd0);
    // R10 reserved kinds
    send_fault(20, 1'b1, 5'd4);
    send_fault(31, 1'b0, 5'd0);
    go_idle();

    // R11 hold
    repeat (3) @(posedge clk);
    #1;
    check(cause == last_cause && !exc_strobe, "R11 cause held", 64'(cause), 64'(last_cause));

    // R7 exception return
    @(negedge clk);
    epcc_in  = 64'hA5A5_0000_1234_5678;
    eret_req = 1'b1;
    @(posedge clk);
    #1;
    check(next_pcc == epcc_in && delayed_pcc == epcc_in, "R7 restore", next_pcc, epcc_in);
    check(!exc_strobe && cause == last_cause, "R7 no fault", 64'(cause), 64'(last_cause));
    @(negedge clk);
    eret_req = 1'b0;

    // R9 back-pressure: fault held through an exception return
    @(negedge clk);
    epcc_in  = 64'h0F0F_1111_2222_3333;
    eret_req = 1'b1;
    #1;
    send_fault(13, 1'b1, 5'd9);
    #1;
    check(!flt_ready, "R9 ready low on eret", 64'(flt_ready), 64'd0);
    @(posedge clk);
    #1;
    check(!exc_strobe && next_pcc == epcc_in, "R9 eret wins", next_pcc, epcc_in);
    @(negedge clk);
    eret_req = 1'b0;
    #1;
    check(flt_ready, "R9 ready restored", 64'(flt_ready), 64'd1);
    go_idle();
    repeat (2) @(posedge clk);

    // R8 system register gate
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        pcc_in[CAP_W-2] = p[0];
        sys_query_idx   = 5'(i);
        #1;
        check(sys_query_denied == (i >= 27 && p == 0), "R8 sysreg gate",
              64'(sys_query_denied), 64'(i >= 27 && p == 0));
      end
    end

    repeat (3) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R2 all faults reported", 64'(exp_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule